// File: doc/BRIEF.md
# Single-Wire ROM Addressing Controller

This block is the addressing layer of a single-wire bus slave. After every presence pulse it collects an 8-bit ROM function command from the bit-level interface, one written bit per time slot, and then runs one of seven addressing operations against a 64-bit identifier that arrives on an input port. The identifier can be sent out, compared against a stream from the master, or walked through in search triplets, so that one slave among many on a shared line can be selected.

The block keeps two flags across transactions. The resume flag records that this slave was the last one picked by full addressing. The speed flag records that the bus runs at the fast rate. On the way out it says whether control now belongs to the device-function layer or whether the slave stays silent until the next bus reset. Bit timing, line driving and the function layer sit outside. The bit layer presents each written bit as a one-cycle `rxValid` strobe. It fetches each bit to be read with a one-cycle `txTake` strobe while `txReady` is high. It reports each bus reset with `resetPulse`, and sets `resetStd` when that reset was long enough to count as a standard-speed reset.

Top module: `romSelectCtrl`

## Requirements
- R1: After a bus reset the block waits for a command: `funcGo`, `waitReset` and `txReady` are low. The command is taken from 8 `rxValid` bits, least significant bit first, and is acted on in the clock cycle after its eighth bit.
- R2: Command 33h clears the resume flag and raises `txReady`. It then offers the 64 identifier bits in index order 0 to 63, one per `txTake`. Index 0 is the least significant bit of the family-code byte. After the last bit, `funcGo` rises.
- R3: Command 55h clears the resume flag and compares the next 64 written bits with identifier bits 0 to 63. When all 64 agree, it sets the resume flag and raises `funcGo`.
- R4: When a written bit disagrees during 55h, `waitReset` rises in the next cycle. Every later written or read slot is ignored until a bus reset.
- R5: Command F0h clears the resume flag. For each identifier bit it offers the true bit, then the inverted bit, each on its own `txTake`, and then reads one written bit. A written bit that differs from the identifier bit raises `waitReset`. After 64 agreeing triplets it sets the resume flag and raises `funcGo`.
- R6: Command CCh clears the resume flag and raises `funcGo`.
- R7: Command A5h raises `funcGo` when the resume flag is set and `waitReset` when it is clear. It leaves the flag unchanged.
- R8: Command 3Ch sets the speed flag (`odMode`), clears the resume flag and raises `funcGo`.
- R9: Command 69h sets the speed flag and clears the resume flag as soon as the command byte is complete. It then compares 64 written bits as in R3. When all agree, it sets the resume flag and raises `funcGo`. On the first disagreement it clears the speed flag and raises `waitReset`.
- R10: Any other command code raises `waitReset` and leaves both flags unchanged.
- R11: `resetPulse` returns the block to command reception from any state and keeps the resume flag. With `resetStd` high it also clears the speed flag; with `resetStd` low the speed flag is kept.
- R12: A slot strobe of the wrong kind for the current step is ignored: `rxValid` while bits are offered, and `txTake` while bits are being received.
- R13: The asynchronous active-low `rstN` clears both flags and puts the block into command reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idValue | input | 64 | Identifier: bits 7:0 family code, 55:8 serial number, 63:56 check byte |
| resetPulse | input | 1 | One-cycle strobe: the bit layer saw a bus reset |
| resetStd | input | 1 | Qualifies `resetPulse` as a standard-speed reset |
| rxValid | input | 1 | One-cycle strobe: a master-written bit is in `rxBit` |
| rxBit | input | 1 | Value of the written bit |
| txTake | input | 1 | One-cycle strobe: the bit layer consumed `txBit` in a read slot |
| txReady | output | 1 | A bit for the master is offered on `txBit` |
| txBit | output | 1 | Bit offered to the master |
| funcGo | output | 1 | Control has passed to the device-function layer |
| waitReset | output | 1 | Slave is idle until the next bus reset |
| rcFlag | output | 1 | Resume flag |
| odMode | output | 1 | Speed flag, high for fast timing |

## Verification
The assertions assume that the bit layer sends at most one slot strobe per cycle of the right kind, and that `resetPulse` can arrive in any cycle. They accept a stray strobe of the wrong kind, which R12 says must be ignored. The stimulus keeps each strobe to a single cycle with an idle cycle after it, raises `resetStd` only together with `resetPulse`, and adds wrong-kind strobes on purpose in receive and send phases. A behavioural model in the bench follows the same inputs and is compared with every output on every cycle. Directed checks then confirm identifier streams, flag values and the drop to the idle state.

// File: rtl/romSelectPkg.sv
package romSelectPkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CODE_READ    = 8'h33;
  localparam logic [CMD_W-1:0] CODE_MATCH   = 8'h55;
  localparam logic [CMD_W-1:0] CODE_SEARCH  = 8'hF0;
  localparam logic [CMD_W-1:0] CODE_SKIP    = 8'hCC;
  localparam logic [CMD_W-1:0] CODE_RESUME  = 8'hA5;
  localparam logic [CMD_W-1:0] CODE_FSKIP   = 8'h3C;
  localparam logic [CMD_W-1:0] CODE_FMATCH  = 8'h69;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_FMATCH,
    ST_SRCH_TRUE,
    ST_SRCH_CMPL,
    ST_SRCH_PICK,
    ST_FUNC,
    ST_WAIT
  } ctrlState_e;

  typedef struct packed {
    logic cmdShift;
    logic cntClr;
    logic idxClr;
    logic idxInc;
    logic setRc;
    logic clrRc;
    logic setOd;
    logic clrOd;
  } dpStrobe_t;

endpackage

// File: rtl/romSelectPath.sv
module romSelectPath
  import romSelectPkg::*;
#(
  parameter int ID_WIDTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                rxBit,
  input  logic [ID_WIDTH-1:0] idValue,
  output logic [CMD_W-1:0]    cmdNext,
  output logic                cmdLast,
  output logic                idBit,
  output logic                idxLast,
  output logic                rcFlag,
  output logic                odMode
);

  localparam int IDX_W = (ID_WIDTH > 1) ? $clog2(ID_WIDTH) : 1;
  localparam int CNT_W = $clog2(CMD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WIDTH - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CMD_W - 1);

  logic [CMD_W-1:0] cmdReg;
  logic [CNT_W-1:0] cmdCnt;
  logic [IDX_W-1:0] idx;

  // Command bits arrive low bit first, so each new bit enters at the top.
  assign cmdNext = {rxBit, cmdReg[CMD_W-1:1]};
  assign cmdLast = (cmdCnt == LAST_CNT);
  assign idxLast = (idx == LAST_IDX);
  assign idBit   = idValue[idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      cmdCnt <= '0;
    end else if (strobe.cntClr) begin
      cmdCnt <= '0;
    end else if (strobe.cmdShift) begin
      cmdReg <= cmdNext;
      cmdCnt <= cmdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (strobe.idxClr) begin
      idx <= '0;
    end else if (strobe.idxInc) begin
      idx <= idx + 1'b1;
    end
  end

  // Resume flag: a set wins over a clear, although the control never asks for both.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcFlag <= 1'b0;
    end else if (strobe.setRc) begin
      rcFlag <= 1'b1;
    end else if (strobe.clrRc) begin
      rcFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odMode <= 1'b0;
    end else if (strobe.setOd) begin
      odMode <= 1'b1;
    end else if (strobe.clrOd) begin
      odMode <= 1'b0;
    end
  end

  AST_RC_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setRc && strobe.clrRc)); // R3

  AST_OD_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setOd && strobe.clrOd)); // R9

endmodule

// File: rtl/romSelectFsm.sv
module romSelectFsm
  import romSelectPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             resetPulse,
  input  logic             resetStd,
  input  logic             rxValid,
  input  logic             rxBit,
  input  logic             txTake,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             cmdLast,
  input  logic             idBit,
  input  logic             idxLast,
  input  logic             rcFlag,
  output dpStrobe_t        strobe,
  output logic             txReady,
  output logic             txBit,
  output logic             funcGo,
  output logic             waitReset
);

  ctrlState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CMD;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (resetPulse) begin
      stateNext     = ST_CMD;
      strobe.cntClr = 1'b1;
      strobe.idxClr = 1'b1;
      strobe.clrOd  = resetStd;
    end else begin
      unique case (state)
        ST_CMD: begin
          if (rxValid) begin
            strobe.cmdShift = 1'b1;
            if (cmdLast) begin
              strobe.idxClr = 1'b1;
              case (cmdNext)
                CODE_READ: begin
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_READ;
                end
                CODE_MATCH: begin
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_MATCH;
                end
                CODE_SEARCH: begin
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_SRCH_TRUE;
                end
                CODE_SKIP: begin
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_FUNC;
                end
                CODE_RESUME: begin
                  stateNext = rcFlag ? ST_FUNC : ST_WAIT;
                end
                CODE_FSKIP: begin
                  strobe.setOd = 1'b1;
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_FUNC;
                end
                CODE_FMATCH: begin
                  strobe.setOd = 1'b1;
                  strobe.clrRc = 1'b1;
                  stateNext    = ST_FMATCH;
                end
                default: stateNext = ST_WAIT;
              endcase
            end
          end
        end
        ST_READ: begin
          if (txTake) begin
            if (idxLast) stateNext     = ST_FUNC;
            else         strobe.idxInc = 1'b1;
          end
        end
        ST_MATCH, ST_FMATCH: begin
          if (rxValid) begin
            if (rxBit != idBit) begin
              stateNext    = ST_WAIT;
              strobe.clrOd = (state == ST_FMATCH);
            end else if (idxLast) begin
              strobe.setRc = 1'b1;
              stateNext    = ST_FUNC;
            end else begin
              strobe.idxInc = 1'b1;
            end
          end
        end
        ST_SRCH_TRUE: begin
          if (txTake) stateNext = ST_SRCH_CMPL;
        end
        ST_SRCH_CMPL: begin
          if (txTake) stateNext = ST_SRCH_PICK;
        end
        ST_SRCH_PICK: begin
          if (rxValid) begin
            if (rxBit != idBit) begin
              stateNext = ST_WAIT;
            end else if (idxLast) begin
              strobe.setRc = 1'b1;
              stateNext    = ST_FUNC;
            end else begin
              strobe.idxInc = 1'b1;
              stateNext     = ST_SRCH_TRUE;
            end
          end
        end
        ST_FUNC, ST_WAIT: stateNext = state;
        default: stateNext = ST_WAIT;
      endcase
    end
  end

  assign txReady   = (state == ST_READ) || (state == ST_SRCH_TRUE) || (state == ST_SRCH_CMPL);
  assign txBit     = (state == ST_SRCH_CMPL) ? ~idBit : idBit;
  assign funcGo    = (state == ST_FUNC);
  assign waitReset = (state == ST_WAIT);

  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && rxValid && cmdLast && cmdNext == CODE_RESUME && !resetPulse)
      |=> (funcGo == $past(rcFlag)) && (waitReset == !$past(rcFlag))); // R7

  AST_MATCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MATCH && rxValid && rxBit != idBit && !resetPulse) |=> waitReset); // R4

  AST_SKIP_CLEARS_RC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && rxValid && cmdLast && cmdNext == CODE_SKIP && !resetPulse)
      |=> funcGo && !rcFlag); // R6

  AST_WAIT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (waitReset && !resetPulse) |=> waitReset); // R4

endmodule

// File: rtl/romSelectCtrl.sv
module romSelectCtrl
  import romSelectPkg::*;
#(
  parameter int ID_WIDTH = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ID_WIDTH-1:0] idValue,
  input  logic                resetPulse,
  input  logic                resetStd,
  input  logic                rxValid,
  input  logic                rxBit,
  input  logic                txTake,
  output logic                txReady,
  output logic                txBit,
  output logic                funcGo,
  output logic                waitReset,
  output logic                rcFlag,
  output logic                odMode
);

  dpStrobe_t        strobe;
  logic [CMD_W-1:0] cmdNext;
  logic             cmdLast;
  logic             idBit;
  logic             idxLast;

  romSelectFsm uFsm (
    .clk       (clk),
    .rstN      (rstN),
    .resetPulse(resetPulse),
    .resetStd  (resetStd),
    .rxValid   (rxValid),
    .rxBit     (rxBit),
    .txTake    (txTake),
    .cmdNext   (cmdNext),
    .cmdLast   (cmdLast),
    .idBit     (idBit),
    .idxLast   (idxLast),
    .rcFlag    (rcFlag),
    .strobe    (strobe),
    .txReady   (txReady),
    .txBit     (txBit),
    .funcGo    (funcGo),
    .waitReset (waitReset)
  );

  romSelectPath #(.ID_WIDTH(ID_WIDTH)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rxBit  (rxBit),
    .idValue(idValue),
    .cmdNext(cmdNext),
    .cmdLast(cmdLast),
    .idBit  (idBit),
    .idxLast(idxLast),
    .rcFlag (rcFlag),
    .odMode (odMode)
  );

  AST_STD_RESET_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    (resetPulse && resetStd) |=> !odMode); // R11

  AST_RESET_KEEPS_RC: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> (rcFlag == $past(rcFlag))); // R11

  AST_RESET_TO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |=> (!funcGo && !waitReset && !txReady)); // R1

endmodule

// File: tb/romSelectCtrl_test.sv
module romSelectCtrl_test;

  localparam logic [63:0] ID_VAL = 64'h9E3A_51C7_0D24_B628;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetPulse = 1'b0, resetStd = 1'b0;
  logic rxValid = 1'b0, rxBit = 1'b0, txTake = 1'b0;
  logic txReady, txBit, funcGo, waitReset, rcFlag, odMode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  romSelectCtrl uut (
    .clk(clk), .rstN(rstN), .idValue(ID_VAL),
    .resetPulse(resetPulse), .resetStd(resetStd),
    .rxValid(rxValid), .rxBit(rxBit), .txTake(txTake),
    .txReady(txReady), .txBit(txBit), .funcGo(funcGo),
    .waitReset(waitReset), .rcFlag(rcFlag), .odMode(odMode)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: phase names, integer counters.
  localparam int M_CMD = 0, M_READ = 1, M_MATCH = 2, M_FMATCH = 3, M_STRUE = 4,
                 M_SCMPL = 5, M_SPICK = 6, M_FUNC = 7, M_WAIT = 8;
  int mState, mIdx, mCnt;
  logic [7:0] mCmd;
  bit mRc, mOd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = M_CMD; mIdx = 0; mCnt = 0; mCmd = 0; mRc = 0; mOd = 0;
    end else if (resetPulse) begin
      mState = M_CMD; mIdx = 0; mCnt = 0;
      if (resetStd) mOd = 0;
    end else begin
      case (mState)
        M_CMD: if (rxValid) begin
          mCmd[mCnt] = rxBit;
          mCnt++;
          if (mCnt == 8) begin
            mCnt = 0; mIdx = 0;
            case (mCmd)
              8'h33: begin mRc = 0; mState = M_READ; end
              8'h55: begin mRc = 0; mState = M_MATCH; end
              8'hF0: begin mRc = 0; mState = M_STRUE; end
              8'hCC: begin mRc = 0; mState = M_FUNC; end
              8'hA5: mState = mRc ? M_FUNC : M_WAIT;
              8'h3C: begin mRc = 0; mOd = 1; mState = M_FUNC; end
              8'h69: begin mRc = 0; mOd = 1; mState = M_FMATCH; end
              default: mState = M_WAIT;
            endcase
          end
        end
        M_READ: if (txTake) begin
          if (mIdx == 63) mState = M_FUNC; else mIdx++;
        end
        M_MATCH, M_FMATCH: if (rxValid) begin
          if (rxBit != ID_VAL[mIdx]) begin
            if (mState == M_FMATCH) mOd = 0;
            mState = M_WAIT;
          end else if (mIdx == 63) begin
            mRc = 1; mState = M_FUNC;
          end else mIdx++;
        end
        M_STRUE: if (txTake) mState = M_SCMPL;
        M_SCMPL: if (txTake) mState = M_SPICK;
        M_SPICK: if (rxValid) begin
          if (rxBit != ID_VAL[mIdx]) mState = M_WAIT;
          else if (mIdx == 63) begin mRc = 1; mState = M_FUNC; end
          else begin mIdx++; mState = M_STRUE; end
        end
        default: ;
      endcase
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eReady, eBit;
      eReady = (mState == M_READ) || (mState == M_STRUE) || (mState == M_SCMPL);
      eBit   = (mState == M_SCMPL) ? ~ID_VAL[mIdx] : ID_VAL[mIdx];
      check(txReady == eReady, "R12 txReady per-cycle", txReady, eReady);
      if (eReady) check(txBit == eBit, "R5 txBit per-cycle", txBit, eBit);
      check(funcGo == (mState == M_FUNC), "R1 funcGo per-cycle", funcGo, mState == M_FUNC);
      check(waitReset == (mState == M_WAIT), "R4 waitReset per-cycle", waitReset, mState == M_WAIT);
      check(rcFlag == mRc, "R11 rcFlag per-cycle", rcFlag, mRc);
      check(odMode == mOd, "R9 odMode per-cycle", odMode, mOd);
    end
  end

  task automatic wbit(input bit b);
    rxValid = 1'b1; rxBit = b;
    @(negedge clk);
    rxValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wbit(c[i]);
  endtask

  task automatic rbit(output bit b);
    int n = 0;
    while (!txReady && n < 10) begin @(negedge clk); n++; end
    b = txBit;
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
    @(negedge clk);
  endtask

  task automatic takeOnly();
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
    @(negedge clk);
  endtask

  task automatic busReset(input bit std);
    resetPulse = 1'b1; resetStd = std;
    @(negedge clk);
    resetPulse = 1'b0; resetStd = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendId(input int badAt);
    for (int i = 0; i < 64; i++) wbit(i == badAt ? ~ID_VAL[i] : ID_VAL[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    bit b, bt, bc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!funcGo && !waitReset && !txReady, "R13 reset state idle", {funcGo, waitReset, txReady}, 0);
    check(!rcFlag && !odMode, "R13 reset flags", {rcFlag, odMode}, 0);

    // R1: partial command does nothing
    for (int i = 0; i < 7; i++) wbit(CODE_BIT(8'h55, i));
    check(!funcGo && !waitReset, "R1 partial command idle", {funcGo, waitReset}, 0);
    busReset(1);

    // R3: full match
    sendCmd(8'h55);
    takeOnly(); // R12: stray read strobe in receive phase
    sendId(-1);
    check(funcGo && rcFlag, "R3 match selects", {funcGo, rcFlag}, 2'b11);

    // R11: reset keeps RC; R7 resume succeeds
    busReset(1);
    check(rcFlag, "R11 rc kept over reset", rcFlag, 1);
    sendCmd(8'hA5);
    check(funcGo && rcFlag, "R7 resume with rc", {funcGo, rcFlag}, 2'b11);

    // R2: read
    busReset(1);
    sendCmd(8'h33);
    check(!rcFlag, "R2 read clears rc", rcFlag, 0);
    got = '0;
    for (int i = 0; i < 64; i++) begin rbit(b); got[i] = b; end
    check(got == ID_VAL, "R2 id stream", got, ID_VAL);
    check(funcGo, "R2 control passes", funcGo, 1);

    // R7: resume without RC
    busReset(1);
    sendCmd(8'hA5);
    check(waitReset && !funcGo, "R7 resume without rc", {waitReset, funcGo}, 2'b10);
    wbit(1); takeOnly();
    check(waitReset && !txReady, "R4 slots ignored in wait", {waitReset, txReady}, 2'b10);

    // R4: match mismatch
    busReset(1);
    sendCmd(8'h55);
    sendId(40);
    check(waitReset && !rcFlag, "R4 mismatch drops", {waitReset, rcFlag}, 2'b10);

    // R5: full search with stray writes during send phases (R12)
    busReset(1);
    sendCmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      if (i == 3) wbit(~ID_VAL[i]);
      rbit(bt); rbit(bc);
      if (i < 4) begin
        check(bt == ID_VAL[i], "R5 search true bit", bt, ID_VAL[i]);
        check(bc == ~ID_VAL[i], "R5 search complement bit", bc, ~ID_VAL[i]);
      end
      wbit(ID_VAL[i]);
    end
    check(funcGo && rcFlag, "R5 search selects", {funcGo, rcFlag}, 2'b11);

    // R5: search dropout
    busReset(1);
    sendCmd(8'hF0);
    for (int i = 0; i < 6; i++) begin
      rbit(bt); rbit(bc);
      wbit(i == 5 ? ~ID_VAL[i] : ID_VAL[i]);
    end
    check(waitReset && !rcFlag, "R5 search dropout", {waitReset, rcFlag}, 2'b10);

    // R6: skip
    busReset(1);
    sendCmd(8'hCC);
    check(funcGo && !rcFlag && !odMode, "R6 skip", {funcGo, rcFlag, odMode}, 3'b100);

    // R8: fast skip, then R11 fast reset keeps OD
    busReset(1);
    sendCmd(8'h3C);
    check(funcGo && odMode && !rcFlag, "R8 fast skip", {funcGo, odMode, rcFlag}, 3'b110);
    busReset(0);
    check(odMode, "R11 fast reset keeps od", odMode, 1);

    // R9: fast match success
    sendCmd(8'h69);
    check(odMode && !rcFlag, "R9 od set at command", {odMode, rcFlag}, 2'b10);
    sendId(-1);
    check(funcGo && rcFlag && odMode, "R9 fast match selects", {funcGo, rcFlag, odMode}, 3'b111);

    // R9: fast match mismatch clears OD
    busReset(0);
    sendCmd(8'h69);
    sendId(10);
    check(waitReset && !odMode, "R9 fast match mismatch", {waitReset, odMode}, 2'b10);

    // R11: standard reset clears OD
    busReset(1);
    sendCmd(8'h3C);
    busReset(1);
    check(!odMode && !funcGo, "R11 std reset clears od", {odMode, funcGo}, 0);

    // R10: unknown code
    sendCmd(8'h00);
    check(waitReset && !funcGo, "R10 unknown code", {waitReset, funcGo}, 2'b10);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit CODE_BIT(input logic [7:0] c, input int i);
    return c[i];
  endfunction

endmodule